// File: doc/BRIEF.md
# Waveform Timer Channel with Compare-Driven Outputs

This block is one timer/counter channel that generates waveforms. A free-running counter steps once per clock while the channel is enabled and not halted. The counter counts up only, or counts up and down as a triangle. In either profile, a match against compare value C can act as the turning point. Three compare values (A, B, C) and an external event feed two output pins. Each pin has its own 2-bit action per event source: none, set, clear or toggle.

Software reaches the channel through a simple register write port and a combinational read port. Command writes enable or disable the channel and issue a software trigger. The external event is picked from the B pin or one of three external clock lines, with a chosen edge. It can also restart the counter. A match on C can halt the count or drop the enabled state. Sticky status flags record every event until software clears them.

Top module: `wave_timer_ch`

Register word addresses (3-bit): 0 command (write), 1 mode, 2 compare A, 3 compare B, 4 compare C, 5 counter value (read), 6 status (read; write-one-to-clear on bits 4:0).

## Requirements
- R1: After synchronous reset the counter, all flags, both pins, the enabled state and the match pulses are 0. The mode word is 0, which selects the B pin as event source, so `tio_b_oe` is 0.
- R2: With mode bits 1:0 = 0, the counter steps +1 each cycle while enabled and not halted. It wraps from all-ones to 0 and sets status bit 0 (overflow).
- R3: With mode bits 1:0 = 1, a counter equal to compare C returns to 0 on the next cycle.
- R4: With mode bits 1:0 = 2, the counter turns downward at all-ones and sets overflow there. With mode bits 1:0 = 3, it turns downward on a match with C. In both profiles it turns upward again at 0.
- R5: Mode bits 17:16, 19:18, 21:20 and 23:22 give the A-pin action for compare A, compare C, the external event and the software trigger. Bits 25:24, 27:26, 29:28 and 31:30 give the B-pin action for compare B, compare C, the external event and the software trigger. Codes: 0 none, 1 set, 2 clear, 3 toggle. The pin changes on the clock edge after the event.
- R6: When several events with a non-zero action reach one pin in the same cycle, one action is applied. Priority is software trigger, then external event, then compare C, then compare A/B.
- R7: Command bit 0 enables the channel and clears a halt. Bit 1 disables it and wins over bit 0. Bit 2 is a software trigger: the counter goes to 0 counting up, a halt is cleared, and the software-trigger actions apply. A trigger alone does not enable counting.
- R8: With mode bit 2 set, a match with C halts counting. The enabled state (status bit 8) stays 1.
- R9: With mode bit 3 set, a match with C clears the enabled state, and counting stops.
- R10: Mode bits 7:6 select the event source: 0 the B pin, 1 to 3 external lines 0 to 2. Bits 5:4 select the edge: 0 none (events ignored), 1 rising, 2 falling, 3 both. A detected event sets status bit 4 and applies the event actions.
- R11: With mode bit 8 set, a detected external event restarts the counter at 0.
- R12: `tio_b_oe` is 0 whenever the event source is the B pin, and 1 otherwise.
- R13: `match_pulse` bits 0, 1 and 2 are high for the single cycle in which a running counter equals A, B or C. Each match sets sticky status bit 1, 2 or 3. A sticky flag holds until a 1 is written to its bit of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data (combinational) |
| xclk_in | input | 3 | External lines usable as event source |
| tio_b_in | input | 1 | B pin input value |
| tio_a_out | output | 1 | A pin output |
| tio_b_out | output | 1 | B pin output value |
| tio_b_oe | output | 1 | B pin output enable |
| match_pulse | output | 3 | Single-cycle compare pulses (bit 0 A, bit 1 B, bit 2 C) |

## Verification
The assertions assume the external and B-pin inputs are synchronous to `clk` and already free of metastability. They also assume compare values are not rewritten while their match is being judged. The pulse check assumes compare values are not rewritten in a matching cycle. The stimulus changes external lines only on falling clock edges. It reprograms compare values only while the counter is far from them or disabled. It never places a compare at 0 in the up-down profile, where a match at the bottom turn could repeat.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMPA = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMPB = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CMPC = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_STS  = 3'd6;

    localparam int CMD_ENA = 0;
    localparam int CMD_DIS = 1;
    localparam int CMD_TRG = 2;

    localparam int FLAG_N = 5;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        WV_UP      = 2'd0,
        WV_UP_RC   = 2'd1,
        WV_UPDN    = 2'd2,
        WV_UPDN_RC = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_e;

    // per-pin action set, most significant field = highest priority source
    typedef struct packed {
        act_e sw;
        act_e ext;
        act_e rc;
        act_e cmp;
    } out_act_t;

    typedef struct packed {
        out_act_t   b;        // 31:24
        out_act_t   a;        // 23:16
        logic [6:0] spare;    // 15:9
        logic       ext_trg;  // 8
        logic [1:0] ext_src;  // 7:6
        edge_e      ext_edge; // 5:4
        logic       dis_rc;   // 3
        logic       stop_rc;  // 2
        wave_e      wave;     // 1:0
    } mode_t;

    typedef struct packed {
        logic sw;
        logic ext;
        logic rc;
        logic cmp;
    } evt_t;

    function automatic logic apply_act(input logic cur, input act_e code);
        case (code)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/wtc_counter.sv
module wtc_counter
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             trig,
    input  wave_e            wave,
    input  logic             rc_hit,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             wrap_evt
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] cnt_nx;
    logic             dn_nx;
    logic             at_max;
    logic             at_zero;
    logic             two_way;
    logic             rc_turn;

    always_comb begin
        at_max   = (cnt == MAXV);
        at_zero  = (cnt == '0);
        two_way  = (wave == WV_UPDN) || (wave == WV_UPDN_RC);
        rc_turn  = rc_hit && ((wave == WV_UP_RC) || (wave == WV_UPDN_RC));
        cnt_nx   = cnt;
        dn_nx    = dir_down;
        wrap_evt = 1'b0;
        if (trig) begin
            cnt_nx = '0;
            dn_nx  = 1'b0;
        end else if (active) begin
            if (!two_way) begin
                if (rc_turn) begin
                    cnt_nx = '0;
                end else if (at_max) begin
                    cnt_nx   = '0;
                    wrap_evt = 1'b1;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end else if (!dir_down) begin
                if (rc_turn || at_max) begin
                    dn_nx    = 1'b1;
                    cnt_nx   = at_zero ? cnt : cnt - 1'b1;
                    wrap_evt = at_max && !rc_turn;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end else begin
                if (at_zero) begin
                    dn_nx  = 1'b0;
                    cnt_nx = cnt + 1'b1;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else begin
            cnt      <= cnt_nx;
            dir_down <= dn_nx;
        end
    end

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && !trig && wave == WV_UP && !at_max) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_RC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (active && !trig && wave == WV_UP_RC && rc_hit) |=> (cnt == '0)); // R3

    AST_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
        (active && !trig && wave == WV_UPDN && !dir_down && at_max) |=> dir_down); // R4

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!active && !trig) |=> $stable(cnt)); // R8

endmodule

// File: rtl/wtc_evt_edge.sv
module wtc_evt_edge
    import wtc_pkg::*;
#(
    parameter int XC_N = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      src,
    input  edge_e           edge_sel,
    input  logic            b_pin,
    input  logic [XC_N-1:0] xclk,
    output logic            hit
);

    localparam int SRC_N = XC_N + 1;

    logic [SRC_N-1:0] cand;
    logic             sel_now;
    logic             sel_prev;

    assign cand    = {xclk, b_pin};
    assign sel_now = cand[src];

    always_ff @(posedge clk) begin
        if (rst) sel_prev <= 1'b0;
        else     sel_prev <= sel_now;
    end

    always_comb begin
        case (edge_sel)
            EDG_RISE: hit = sel_now & ~sel_prev;
            EDG_FALL: hit = ~sel_now & sel_prev;
            EDG_BOTH: hit = sel_now ^ sel_prev;
            default:  hit = 1'b0;
        endcase
    end

    AST_NO_EDGE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == EDG_NONE) |-> !hit); // R10

endmodule

// File: rtl/wtc_pin_action.sv
module wtc_pin_action
    import wtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_t     ev,
    input  out_act_t cfg,
    output logic     pin
);

    act_e code;

    // later assignments override earlier ones: lowest priority first
    always_comb begin
        code = ACT_NONE;
        if (ev.cmp && cfg.cmp != ACT_NONE) code = cfg.cmp;
        if (ev.rc  && cfg.rc  != ACT_NONE) code = cfg.rc;
        if (ev.ext && cfg.ext != ACT_NONE) code = cfg.ext;
        if (ev.sw  && cfg.sw  != ACT_NONE) code = cfg.sw;
    end

    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= apply_act(pin, code);
    end

    AST_SW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev.sw && cfg.sw == ACT_SET) |=> pin); // R6

    AST_SW_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev.sw && cfg.sw == ACT_CLR) |=> !pin); // R6

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ev.sw && !ev.ext && !ev.rc && !ev.cmp) |=> $stable(pin)); // R5

endmodule

// File: rtl/wave_timer_ch.sv
module wave_timer_ch
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int XC_N  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [XC_N-1:0]   xclk_in,
    input  logic              tio_b_in,
    output logic              tio_a_out,
    output logic              tio_b_out,
    output logic              tio_b_oe,
    output logic [2:0]        match_pulse
);

    localparam int PIN_N = 2;

    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cmp_c_q;
    logic             clk_en_q;
    logic             halt_q;
    logic [FLAG_N-1:0] sts_q;

    logic [CNT_W-1:0] cnt;
    logic             dir_down;
    logic             wrap_evt;
    logic             ext_hit;

    logic cmd_wr, sw_trig, en_cmd, dis_cmd;
    logic ext_trig, trig_any, active;
    logic hit_a, hit_b, hit_c;
    logic [FLAG_N-1:0] new_flags, clr_mask;

    evt_t     pin_ev  [PIN_N];
    out_act_t pin_cfg [PIN_N];
    logic     pin_q   [PIN_N];

    always_comb begin
        cmd_wr   = wr_en && (wr_addr == ADR_CMD);
        sw_trig  = cmd_wr && wr_data[CMD_TRG];
        en_cmd   = cmd_wr && wr_data[CMD_ENA];
        dis_cmd  = cmd_wr && wr_data[CMD_DIS];
        ext_trig = ext_hit && mode_q.ext_trg;
        trig_any = sw_trig || ext_trig;
        active   = clk_en_q && !halt_q;
        hit_a    = active && (cnt == cmp_a_q);
        hit_b    = active && (cnt == cmp_b_q);
        hit_c    = active && (cnt == cmp_c_q);
        new_flags = {ext_hit, hit_c, hit_b, hit_a, wrap_evt};
        clr_mask  = (wr_en && wr_addr == ADR_STS) ? wr_data[FLAG_N-1:0] : '0;
    end

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            cmp_c_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_MODE: mode_q  <= mode_t'(wr_data);
                ADR_CMPA: cmp_a_q <= wr_data[CNT_W-1:0];
                ADR_CMPB: cmp_b_q <= wr_data[CNT_W-1:0];
                ADR_CMPC: cmp_c_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // run control
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en_q <= 1'b0;
            halt_q   <= 1'b0;
        end else begin
            if (dis_cmd)                       clk_en_q <= 1'b0;
            else if (en_cmd)                   clk_en_q <= 1'b1;
            else if (hit_c && mode_q.dis_rc)   clk_en_q <= 1'b0;

            if (trig_any || en_cmd)            halt_q <= 1'b0;
            else if (hit_c && mode_q.stop_rc)  halt_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_q & ~clr_mask) | new_flags;
    end

    wtc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .trig     (trig_any),
        .wave     (mode_q.wave),
        .rc_hit   (hit_c),
        .cnt      (cnt),
        .dir_down (dir_down),
        .wrap_evt (wrap_evt)
    );

    wtc_evt_edge #(.XC_N(XC_N)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .src      (mode_q.ext_src),
        .edge_sel (mode_q.ext_edge),
        .b_pin    (tio_b_in),
        .xclk     (xclk_in),
        .hit      (ext_hit)
    );

    always_comb begin
        pin_ev[0]  = '{sw: sw_trig, ext: ext_hit, rc: hit_c, cmp: hit_a};
        pin_ev[1]  = '{sw: sw_trig, ext: ext_hit, rc: hit_c, cmp: hit_b};
        pin_cfg[0] = mode_q.a;
        pin_cfg[1] = mode_q.b;
    end

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        wtc_pin_action u_pin (
            .clk (clk),
            .rst (rst),
            .ev  (pin_ev[p]),
            .cfg (pin_cfg[p]),
            .pin (pin_q[p])
        );
    end

    assign tio_a_out   = pin_q[0];
    assign tio_b_out   = pin_q[1];
    assign tio_b_oe    = (mode_q.ext_src != 2'd0);
    assign match_pulse = {hit_c, hit_b, hit_a};

    always_comb begin
        case (rd_addr)
            ADR_MODE: rd_data = DATA_W'(mode_q);
            ADR_CMPA: rd_data = DATA_W'(cmp_a_q);
            ADR_CMPB: rd_data = DATA_W'(cmp_b_q);
            ADR_CMPC: rd_data = DATA_W'(cmp_c_q);
            ADR_CNT:  rd_data = DATA_W'(cnt);
            ADR_STS:  rd_data = {20'd0, dir_down, pin_q[1], pin_q[0], clk_en_q, 3'd0, sts_q};
            default:  rd_data = '0;
        endcase
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (hit_a && !trig_any && !wr_en && cnt != '0) |=> !hit_a); // R13

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_q[1] && !(wr_en && wr_addr == ADR_STS && wr_data[1])) |=> sts_q[1]); // R13

    AST_RC_DISABLE: assert property (@(posedge clk) disable iff (rst)
        (hit_c && mode_q.dis_rc && !cmd_wr) |=> !clk_en_q); // R9

    AST_RC_HALT_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        (hit_c && mode_q.stop_rc && !mode_q.dis_rc && clk_en_q && !cmd_wr) |=> clk_en_q); // R8

endmodule

// File: tb/test_wave_timer_ch.sv
module test_wave_timer_ch;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  xclk = '0;
    logic        tio_b_in = 1'b0;
    logic        tio_a_out, tio_b_out, tio_b_oe;
    logic [2:0]  match_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wave_timer_ch #(.CNT_W(CW)) i_wave_timer_ch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .xclk_in(xclk), .tio_b_in(tio_b_in),
        .tio_a_out(tio_a_out), .tio_b_out(tio_b_out), .tio_b_oe(tio_b_oe),
        .match_pulse(match_pulse)
    );

    typedef struct packed {
        logic [31:0] mode;
        logic [7:0]  ra;
        logic [7:0]  rb;
        logic [7:0]  rc;
        logic [15:0] n;
        logic [7:0]  e_cnt;
        logic        e_a;
        logic        e_b;
        logic        e_en;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0003_0040, 8'd5,   8'd200, 8'd250, 16'd10,  8'd10,  1'b1, 1'b0, 1'b1}, // R2 R5 up, A toggles at A
        '{32'h0B06_0041, 8'd3,   8'd2,   8'd7,   16'd19,  8'd3,   1'b1, 1'b1, 1'b1}, // R3 R5 restart at C
        '{32'h000C_0043, 8'd200, 8'd200, 8'd4,   16'd6,   8'd2,   1'b1, 1'b0, 1'b1}, // R4 turn at C
        '{32'h0000_0042, 8'd1,   8'd1,   8'd1,   16'd260, 8'd250, 1'b0, 1'b0, 1'b1}, // R4 turn at top
        '{32'h0000_0040, 8'd100, 8'd100, 8'd100, 16'd258, 8'd2,   1'b0, 1'b0, 1'b1}, // R2 wrap
        '{32'h0000_0045, 8'd100, 8'd100, 8'd9,   16'd30,  8'd0,   1'b0, 1'b0, 1'b1}, // R8 halt at C
        '{32'h0000_0048, 8'd100, 8'd100, 8'd6,   16'd20,  8'd7,   1'b0, 1'b0, 1'b0}  // R9 disable at C
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst = 1'b1; xclk = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(3'd5, v); chk("R1 count", v, 32'd0);
        rd(3'd6, v); chk("R1 status", v, 32'd0);
        chk("R1 pin A", {31'd0, tio_a_out}, 32'd0);
        chk("R1 oe", {31'd0, tio_b_oe}, 32'd0);
        chk("R1 pulses", {29'd0, match_pulse}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(3'd2, {24'd0, VECS[i].ra});
            wr(3'd3, {24'd0, VECS[i].rb});
            wr(3'd4, {24'd0, VECS[i].rc});
            wr(3'd1, VECS[i].mode);
            wr(3'd0, 32'h5);
            wait_n(int'(VECS[i].n));
            rd(3'd5, v); chk($sformatf("R2/R3/R4 vec%0d count", i), v, {24'd0, VECS[i].e_cnt});
            chk($sformatf("R5 vec%0d pin A", i), {31'd0, tio_a_out}, {31'd0, VECS[i].e_a});
            chk($sformatf("R5 vec%0d pin B", i), {31'd0, tio_b_out}, {31'd0, VECS[i].e_b});
            rd(3'd6, v); chk($sformatf("R8/R9 vec%0d enabled", i), {31'd0, v[8]}, {31'd0, VECS[i].e_en});
        end

        // R12 B pin as event source is not driven
        do_reset();
        wr(3'd3, 32'd3);
        wr(3'd1, 32'h0300_0000);
        wr(3'd0, 32'h5);
        wait_n(6);
        chk("R12 oe with B source", {31'd0, tio_b_oe}, 32'd0);
        wr(3'd1, 32'h0300_0040);
        chk("R12 oe with line source", {31'd0, tio_b_oe}, 32'd1);

        // R7 software trigger actions and commands
        do_reset();
        wr(3'd1, 32'hC040_0040);
        wr(3'd0, 32'h4);
        chk("R7 sw set A", {31'd0, tio_a_out}, 32'd1);
        chk("R7 sw toggle B", {31'd0, tio_b_out}, 32'd1);
        wait_n(3);
        rd(3'd5, v); chk("R7 trigger alone no count", v, 32'd0);
        wr(3'd0, 32'h4);
        chk("R7 second toggle B", {31'd0, tio_b_out}, 32'd0);
        wr(3'd0, 32'h1);
        wait_n(5);
        wr(3'd0, 32'h3);
        wait_n(3);
        rd(3'd5, v); chk("R7 disable freezes count", v, 32'd6);

        // R13 single-cycle pulse, sticky flags, clear
        do_reset();
        wr(3'd2, 32'd4);
        wr(3'd3, 32'd200);
        wr(3'd4, 32'd200);
        wr(3'd1, 32'h0000_0040);
        wr(3'd0, 32'h5);
        wait_n(4);
        chk("R13 pulse A high", {29'd0, match_pulse}, 32'd1);
        wait_n(1);
        chk("R13 pulse A gone", {29'd0, match_pulse}, 32'd0);
        rd(3'd6, v); chk("R13 sticky A flag", {27'd0, v[4:0]}, 32'h02);
        wr(3'd6, 32'h02);
        rd(3'd6, v); chk("R13 flag cleared", {27'd0, v[4:0]}, 32'h00);
        wait_n(260);
        rd(3'd6, v); chk("R2 overflow flag", {31'd0, v[0]}, 32'd1);

        // R6 R10 R11 event priority, trigger, edge choice
        do_reset();
        wr(3'd2, 32'd4);
        wr(3'd3, 32'd200);
        wr(3'd4, 32'd200);
        wr(3'd1, 32'h0012_0150);
        wr(3'd0, 32'h5);
        wait_n(4);
        xclk[0] = 1'b1;
        @(negedge clk);
        chk("R6 event set beats compare clear", {31'd0, tio_a_out}, 32'd1);
        rd(3'd5, v); chk("R11 event restarts count", v, 32'd0);
        rd(3'd6, v); chk("R10 event flag", {27'd0, v[4:0]}, 32'h12);
        wr(3'd2, 32'd200);
        wr(3'd1, 32'h0032_0140);
        xclk[0] = 1'b0;
        wait_n(2);
        xclk[0] = 1'b1;
        wait_n(2);
        chk("R10 edge none ignored", {31'd0, tio_a_out}, 32'd1);
        wr(3'd1, 32'h0032_0060);
        xclk[0] = 1'b0;
        @(negedge clk);
        chk("R10 falling edge toggles", {31'd0, tio_a_out}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule